// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B. Each direction owns a storage register. The A-side register samples bus A when its capture strobe rises, and the B-side register samples bus B when its own strobe rises. The two capture strobes are independent of each other. For each direction, a select input chooses what is sent across: either the live value on the opposite bus, or the value held in that direction's register.

An active-low enable and a direction input decide which bus, if any, the block drives. When the enable is high, the block drives neither bus. Capture still works in that state, because loading a register never depends on the enable or the direction.

A parameter turns the block into an inverting transceiver. The inverting form applies the complement to both the live path and the stored path.

Each bus is modelled at the block edge as three signals: an input carrying the resolved bus value, an output, and an output enable. A surrounding tri-state pad or a bus model combines these. Because the register samples the resolved bus value, capturing a bus while the block drives it stores the driven value.

The capture strobes are level signals that are synchronous to the core clock. A load happens on the first clock edge that finds a strobe high after it was low. The loaded value is visible at the outputs from that edge on.

Top module: `registered_bus_xcvr`

## Requirements
- R1: On the first `clk` rising edge that samples `cap_ab` high after a low sample, the A-side register loads the value of `a_i`. This happens whatever the values of `en_n` and `dir`.
- R2: On the first `clk` rising edge that samples `cap_ba` high after a low sample, the B-side register loads the value of `b_i`. This happens whatever the values of `en_n` and `dir`.
- R3: While a capture strobe stays high over consecutive samples, its register does not load again, even if the bus value changes.
- R4: When `sel_ab` = 0, `b_o` equals the live `a_i` in the same cycle. With INVERT=1 it equals the complement of `a_i`.
- R5: When `sel_ab` = 1, `b_o` equals the A-side register.
- R6: When `sel_ba` = 0, `a_o` follows the live `b_i` in the same way as R4. When `sel_ba` = 1, `a_o` equals the B-side register.
- R7: When `en_n` = 1, both `a_oe` and `b_oe` are 0.
- R8: When `en_n` = 0 and `dir` = 1, only `b_oe` is 1. When `en_n` = 0 and `dir` = 0, only `a_oe` is 1. The two output enables are never 1 together.
- R9: With INVERT=1, each register stores the complement of its bus. The stored path then outputs that register unchanged, so both the live path and the stored path deliver the complement.
- R10: Changing a select while the live value and the stored value agree leaves that output unchanged (make-before-break).
- R11: Capturing the bus that the block is driving stores the value being driven.
- R12: After `rst_n` is asserted, both registers hold all zeros until their first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; captures occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| cap_ab | input | 1 | Capture strobe for the A-side register |
| cap_ba | input | 1 | Capture strobe for the B-side register |
| a_i | input | W | Resolved value on bus A |
| a_o | output | W | Value driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_i | input | W | Resolved value on bus B |
| b_o | output | W | Value driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
A corrupted register shows up the moment the matching select is set to stored and the block drives the opposite bus. The wrong value appears with no further clock, because the stored path is combinational from the register. A broken edge detector shows up one edge after the strobe rises, either as a missing load or as a repeated load while the strobe is held high. A fault in the enable decode shows up immediately as the wrong bus driven, or as both buses driven at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

endpackage

// File: rtl/xcvr_capture_lane.sv
module xcvr_capture_lane #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] stored_o
);

    typedef struct packed {
        logic         prev;
        logic [W-1:0] data;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d      = lane_q;
        lane_d.prev = cap_i;
        if (cap_i && !lane_q.prev) begin
            lane_d.data = INVERT ? ~bus_i : bus_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign stored_o = lane_q.data;

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         use_stored_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] stored_i,
    output logic [W-1:0] out_o
);

    logic [W-1:0] live_x;
    logic [W-1:0] sel_vec;

    always_comb begin
        live_x  = INVERT ? ~live_i : live_i;
        sel_vec = {W{use_stored_i}};
        // The consensus term holds a bit steady when both sources agree.
        out_o   = (stored_i & sel_vec) | (live_x & ~sel_vec) | (stored_i & live_x);
    end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic en_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);

    drive_e drive;

    always_comb begin
        if (en_n) begin
            drive = DRV_NONE;
        end else if (dir) begin
            drive = DRV_B;
        end else begin
            drive = DRV_A;
        end
        a_oe = (drive == DRV_A);
        b_oe = (drive == DRV_B);
    end

endmodule

// File: rtl/registered_bus_xcvr.sv
module registered_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] a_o,
    output logic         a_oe,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] b_o,
    output logic         b_oe
);

    localparam int NDIR = 2;

    logic [NDIR-1:0]        cap_vec;
    logic [NDIR-1:0]        sel_vec;
    logic [NDIR-1:0][W-1:0] src_bus;
    logic [NDIR-1:0][W-1:0] stored;
    logic [NDIR-1:0][W-1:0] routed;
    logic [W-1:0]           stored_ab;
    logic [W-1:0]           stored_ba;

    // index 0 carries A toward B, index 1 carries B toward A
    assign cap_vec = {cap_ba, cap_ab};
    assign sel_vec = {sel_ba, sel_ab};
    assign src_bus = {b_i, a_i};

    for (genvar g = 0; g < NDIR; g++) begin : g_path
        xcvr_capture_lane #(.W(W), .INVERT(INVERT)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_i    (cap_vec[g]),
            .bus_i    (src_bus[g]),
            .stored_o (stored[g])
        );
        xcvr_path_mux #(.W(W), .INVERT(INVERT)) u_mux (
            .use_stored_i (sel_vec[g] == SRC_STORED),
            .live_i       (src_bus[g]),
            .stored_i     (stored[g]),
            .out_o        (routed[g])
        );
    end

    xcvr_drive_ctl u_ctl (
        .en_n (en_n),
        .dir  (dir),
        .a_oe (a_oe),
        .b_oe (b_oe)
    );

    assign stored_ab = stored[0];
    assign stored_ba = stored[1];
    assign b_o       = routed[0];
    assign a_o       = routed[1];

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         cap_ab,
    input logic         cap_ba,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] b_o,
    input logic         a_oe,
    input logic         b_oe,
    input logic [W-1:0] stored_ab,
    input logic [W-1:0] stored_ba
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    function automatic logic [W-1:0] xf(input logic [W-1:0] v);
        return INVERT ? ~v : v;
    endfunction

    a_r8_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    a_r7_both_released: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> (!a_oe && !b_oe));

    a_r8_dir_picks_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && dir) |-> (b_oe && !a_oe));

    a_r1_load_a: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(cap_ab)) |=> (stored_ab == xf($past(a_i))));

    a_r2_load_b: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(cap_ba)) |=> (stored_ba == xf($past(b_i))));

    a_r3_held_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cap_ab && $past(cap_ab)) |=> $stable(stored_ab));

    a_r10_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $stable(a_i) && $stable(stored_ab) && (xf(a_i) == stored_ab))
            |-> $stable(b_o));

endmodule

bind registered_bus_xcvr xcvr_checker #(.W(W), .INVERT(INVERT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_n      (en_n),
    .dir       (dir),
    .sel_ab    (sel_ab),
    .cap_ab    (cap_ab),
    .cap_ba    (cap_ba),
    .a_i       (a_i),
    .b_i       (b_i),
    .b_o       (b_o),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .stored_ab (stored_ab),
    .stored_ba (stored_ba)
);

// File: tb/tb_registered_bus_xcvr.sv
module tb_registered_bus_xcvr;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic cap_ab = 1'b0, cap_ba = 1'b0;
    logic [7:0] ext_a = '0, ext_b = '0;

    logic [7:0] a_i, a_o, b_i, b_o;
    logic       a_oe, b_oe;
    logic [7:0] ia_i, ia_o, ib_i, ib_o;
    logic       ia_oe, ib_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // bus model: external driver only on the bus the block releases
    assign a_i  = a_oe  ? a_o  : ext_a;
    assign b_i  = b_oe  ? b_o  : ext_b;
    assign ia_i = ia_oe ? ia_o : ext_a;
    assign ib_i = ib_oe ? ib_o : ext_b;

    registered_bus_xcvr #(.W(8), .INVERT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_i(a_i), .a_o(a_o), .a_oe(a_oe), .b_i(b_i), .b_o(b_o), .b_oe(b_oe)
    );

    registered_bus_xcvr #(.W(8), .INVERT(1'b1)) dut_inv (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_i(ia_i), .a_o(ia_o), .a_oe(ia_oe), .b_i(ib_i), .b_o(ib_o), .b_oe(ib_oe)
    );

    typedef struct packed {
        logic       en_n;
        logic       dir;
        logic       sab;
        logic       sba;
        logic [7:0] a;
        logic [7:0] b;
        logic       eoa;
        logic       eob;
        logic [7:0] exp;
    } vec_t;

    // registers preloaded with A=3C, B=A5 before this table runs
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h11},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h3C},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b1, 1'b0, 8'h22},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22, 1'b1, 1'b0, 8'hA5},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h0F, 1'b0, 1'b1, 8'hF0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h0F},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit to_b);
        @(negedge clk);
        if (to_b) cap_ba = 1'b1; else cap_ab = 1'b1;
        @(negedge clk);
        cap_ab = 1'b0;
        cap_ba = 1'b0;
    endtask

    task automatic set_ctl(input logic e, input logic d, input logic sa, input logic sb);
        en_n = e; dir = d; sel_ab = sa; sel_ba = sb;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: registers are zero after reset
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        check("R12 stored A after reset", b_o, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        check("R12 stored B after reset", a_o, 8'h00);

        // R1 R2 R7: capture while both buses are released
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ext_a = 8'h3C; ext_b = 8'hA5;
        check("R7 a_oe released", {7'd0, a_oe}, 8'h00);
        check("R7 b_oe released", {7'd0, b_oe}, 8'h00);
        pulse(1'b0);
        pulse(1'b1);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        check("R1 A captured while disabled", b_o, 8'h3C);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 B captured while disabled", a_o, 8'hA5);

        // R4 R5 R6 R7 R8: table of live/stored and enable patterns
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ext_a = VECS[i].a; ext_b = VECS[i].b;
            set_ctl(VECS[i].en_n, VECS[i].dir, VECS[i].sab, VECS[i].sba);
            check("R8 a_oe", {7'd0, a_oe}, {7'd0, VECS[i].eoa});
            check("R8 b_oe", {7'd0, b_oe}, {7'd0, VECS[i].eob});
            if (VECS[i].eob) check("R4/R5 b_o", b_o, VECS[i].exp);
            if (VECS[i].eoa) check("R6 a_o", a_o, VECS[i].exp);
        end

        // R3: held strobe loads once
        @(negedge clk);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ext_a = 8'h77; cap_ab = 1'b1;
        @(negedge clk);
        ext_a = 8'h99;
        repeat (3) @(negedge clk);
        cap_ab = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 held strobe no reload", b_o, 8'h77);

        // R10: select switch with agreeing sources
        ext_a = 8'h77;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 live equal", b_o, 8'h77);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R10 stored equal", b_o, 8'h77);
        ext_a = 8'h12;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 live differs", b_o, 8'h12);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R10 back to stored", b_o, 8'h77);

        // R11: capture the bus the block drives
        ext_a = 8'h5A; ext_b = 8'h00;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        pulse(1'b1);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R11 driven value stored", a_o, 8'h5A);

        // R9: inverting instance
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'hC3; #1;
        check("R9 inverted live A->B", ib_o, 8'h3C);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ext_a = 8'h0F;
        pulse(1'b0);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R9 inverted stored A->B", ib_o, 8'hF0);
        ext_b = 8'h81;
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 inverted live B->A", ia_o, 8'h7E);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule